// File: doc/BRIEF.md
# Circular Frame Buffer Fetch Address Generator

This block supplies burst addresses to the video fetch engine that streams a frame buffer out of memory. The buffer is a ring: one register gives the base of the ring, another gives the base address of the last burst in the ring, and a third gives the address at which every new frame begins. While fetching is enabled, the block holds a burst request with an address. Each acknowledged burst moves the pointer on by one transfer. After the burst at the last-burst address, the pointer returns to the ring base.

Software scrolls the picture by moving the frame-start register anywhere inside the ring. The new value is picked up at the next vertical sync, so a frame may cross the end of the ring partway down the screen. A request that is waiting for its acknowledge is never disturbed. A vertical sync that arrives during such a wait is remembered, and the pointer reloads when that burst completes.

Top module: `fb_ring_addr_gen`

## Requirements
- R1: After reset, `fetch_req` is low and `fetch_addr` is zero.
- R2: After an acknowledged burst whose address is below the last-burst register, the next address is the previous one plus the transfer size (16 bytes by default).
- R3: After an acknowledged burst whose address is equal to or above the last-burst register, the next address is the ring base register.
- R4: A `vsync` pulse while no request is waiting loads the frame-start register into the address on the following clock edge.
- R5: A `vsync` pulse while a request is waiting is remembered. When that request is acknowledged, the next address is the frame-start register, taking the place of the step or wrap.
- R6: Once raised, `fetch_req` stays high and `fetch_addr` stays unchanged until `fetch_ack` is seen with it, whatever `vsync` and register writes do meanwhile.
- R7: `fetch_req` rises on the edge after `run` is high. If `run` is low when a request is acknowledged, `fetch_req` drops on that edge.
- R8: A write with `cfg_wr` high stores `cfg_data` into the register chosen by `cfg_sel`: 0 selects frame start, 1 selects ring base, and 2 selects last burst. Code 3 changes no register. The low log2(transfer size) bits of the stored value are cleared.
- R9: Every address on `fetch_addr` is aligned to the transfer size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 frame start, 1 ring base, 2 last burst, 3 none |
| cfg_data | input | AW | Register write data |
| vsync | input | 1 | Vertical sync pulse, one cycle |
| run | input | 1 | Keep issuing burst requests while high |
| fetch_req | output | 1 | Burst request |
| fetch_addr | output | AW | Burst base address |
| fetch_ack | input | 1 | Burst accepted; ignored while `fetch_req` is low |

## Verification
The embedded properties assume that `fetch_ack` only carries meaning while `fetch_req` is high, and that the register values describe a ring in which the base does not exceed the last-burst address. The stimulus keeps to this. It programs base and last-burst values that form valid rings, some of them only four bursts long, and it drives the acknowledge with and without stall cycles. It also issues `vsync` both while the block is idle and while a request is waiting. One frame-start value is placed beyond the last burst to exercise the equal-or-above wrap rule.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

  typedef enum logic [1:0] {
    SEL_FRAME = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_LAST  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_WRAP = 2'd2,
    OP_LOAD = 2'd3
  } ptr_op_e;

endpackage

// File: rtl/fbr_regs.sv
module fbr_regs
  import fbr_pkg::*;
#(
  parameter int AW  = 32,
  parameter int LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] data,
  output logic [AW-1:0] frame_q,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] last_q
);
  localparam int NREG = 3;
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << LSB) - 1);

  logic [AW-1:0] aligned;
  assign aligned = data & ~LOW_MASK;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          en;
    logic [AW-1:0] q;
    assign en = wr && (sel == 2'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= aligned;
      end
    end
  end

  assign frame_q = g_reg[0].q;
  assign base_q  = g_reg[1].q;
  assign last_q  = g_reg[2].q;

  AST_SEL_NONE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_NONE) |=> ($stable(frame_q) && $stable(base_q) && $stable(last_q))); // R8

  AST_REG_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ((frame_q & LOW_MASK) == '0) && ((base_q & LOW_MASK) == '0) && ((last_q & LOW_MASK) == '0)); // R8

endmodule

// File: rtl/fbr_req.sv
module fbr_req (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic req,
  output logic hold,
  output logic fire
);
  logic req_q;
  logic req_d;

  always_comb begin
    req_d = (req_q & ~ack) | run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req  = req_q;
  assign hold = req_q & ~ack;
  assign fire = req_q & ack;

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req); // R6

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !run) |=> !req); // R7

  AST_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> req); // R7

endmodule

// File: rtl/fbr_sync.sv
module fbr_sync
  import fbr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    vsync,
  input  logic    hold,
  input  logic    fire,
  input  logic    at_end,
  output ptr_op_e op
);
  logic pend_q;
  logic pend_d;
  logic want;

  assign want = vsync | pend_q;

  always_comb begin
    op = OP_HOLD;
    if (!hold && want) begin
      op = OP_LOAD;
    end else if (fire) begin
      op = at_end ? OP_WRAP : OP_STEP;
    end
    pend_d = hold & want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  AST_VSYNC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && vsync) |=> pend_q); // R5

  AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && fire) |-> (op == OP_LOAD)); // R5

endmodule

// File: rtl/fbr_ptr.sv
module fbr_ptr
  import fbr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int XFER_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ptr_op_e       op,
  input  logic [AW-1:0] frame,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] last,
  output logic [AW-1:0] ptr,
  output logic          at_end
);
  localparam int LSB = $clog2(XFER_BYTES);
  localparam logic [AW-1:0] STEP     = AW'(XFER_BYTES);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << LSB) - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = (op != OP_HOLD);
    unique case (op)
      OP_STEP: ptr_d = ptr_q + STEP;
      OP_WRAP: ptr_d = base;
      OP_LOAD: ptr_d = frame;
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr    = ptr_q;
  assign at_end = (ptr_q >= last);

  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (ptr_q == $past(ptr_q) + STEP)); // R2

  AST_WRAP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRAP) |=> (ptr_q == $past(base))); // R3

  AST_LOAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (ptr_q == $past(frame))); // R4

  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ptr_q & LOW_MASK) == '0)); // R9

endmodule

// File: rtl/fb_ring_addr_gen.sv
module fb_ring_addr_gen
  import fbr_pkg::*;
#(
  parameter int AW         = 32,
  parameter int XFER_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  input  logic          vsync,
  input  logic          run,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack
);
  localparam int LSB = $clog2(XFER_BYTES);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  logic [AW-1:0] frame_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] last_q;
  logic          hold;
  logic          fire;
  logic          at_end;
  ptr_op_e       op;

  fbr_regs #(.AW(AW), .LSB(LSB)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr      (cfg_wr),
    .sel     (cfg_sel),
    .data    (cfg_data),
    .frame_q (frame_q),
    .base_q  (base_q),
    .last_q  (last_q)
  );

  fbr_req u_req (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   (run),
    .ack   (fetch_ack),
    .req   (fetch_req),
    .hold  (hold),
    .fire  (fire)
  );

  fbr_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_sn),
    .vsync  (vsync),
    .hold   (hold),
    .fire   (fire),
    .at_end (at_end),
    .op     (op)
  );

  fbr_ptr #(.AW(AW), .XFER_BYTES(XFER_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_sn),
    .op     (op),
    .frame  (frame_q),
    .base   (base_q),
    .last   (last_q),
    .ptr    (fetch_addr),
    .at_end (at_end)
  );

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_sn)
    (fetch_req && !fetch_ack) |=> $stable(fetch_addr)); // R6

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_sn) |-> (!fetch_req && fetch_addr == '0)); // R1

endmodule

// File: tb/sim_fb_ring_addr_gen.sv
module sim_fb_ring_addr_gen;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] a;
    string       tag;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic        vsync;
  logic        run;
  logic        fetch_req;
  logic [31:0] fetch_addr;
  logic        fetch_ack;

  int checks;
  int fails;
  bit started;

  exp_t        q[$];
  exp_t        e;
  logic [31:0] sb_base;
  logic [31:0] sb_last;
  logic [31:0] exp_next;
  string       exp_tag;
  bit          hold_seen;
  logic [31:0] hold_addr;

  fb_ring_addr_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .vsync      (vsync),
    .run        (run),
    .fetch_req  (fetch_req),
    .fetch_addr (fetch_addr),
    .fetch_ack  (fetch_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every handshake, checks address hold
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (hold_seen && fetch_req) begin
        check(fetch_addr === hold_addr, "R6 address held while waiting", fetch_addr, hold_addr);
      end
      if (fetch_req && fetch_ack) begin
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected burst", fetch_addr, 32'h0);
        end else begin
          e = q.pop_front();
          check(fetch_addr === e.a, e.tag, fetch_addr, e.a);
        end
      end
      hold_seen = fetch_req && !fetch_ack;
      hold_addr = fetch_addr;
    end
  end

  task automatic cfg(input logic [1:0] s, input logic [31:0] d);
    cfg_sel  = s;
    cfg_data = d;
    cfg_wr   = 1'b1;
    @(posedge clk); #1;
    cfg_wr   = 1'b0;
    if (s == 2'd1) sb_base = d & ~32'hF;
    if (s == 2'd2) sb_last = d & ~32'hF;
  endtask

  task automatic pulse_vsync();
    vsync = 1'b1;
    @(posedge clk); #1;
    vsync = 1'b0;
  endtask

  // expected ring sequence from the requirements (R2 step, R3 wrap)
  task automatic push_ring(input logic [31:0] first, input int n, input string tag0);
    logic [31:0] a;
    string t;
    a = first;
    t = tag0;
    for (int i = 0; i < n; i++) begin
      q.push_back('{a: a, tag: t});
      if (a >= sb_last) begin
        a = sb_base;
        t = "R3 wrap to base";
      end else begin
        a = a + 32'd16;
        t = "R2 step";
      end
    end
    exp_next = a;
    exp_tag  = t;
  endtask

  // driver: keeps run high until n handshakes have occurred
  task automatic bursts(input int n, input bit stall);
    int done;
    int k;
    done = 0;
    k = 0;
    run = 1'b1;
    while (done < n) begin
      fetch_ack = !(stall && (k % 3 == 1));
      k++;
      @(negedge clk); #1;
      if (fetch_req && fetch_ack) done++;
      @(posedge clk); #1;
    end
    fetch_ack = 1'b0;
    run = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] h;
    checks = 0; fails = 0; started = 0; hold_seen = 0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 2'd0; cfg_data = '0;
    vsync = 1'b0; run = 1'b0; fetch_ack = 1'b0;
    sb_base = '0; sb_last = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    started = 1;
    @(negedge clk);
    check(fetch_req === 1'b0, "R1 req after reset", {31'b0, fetch_req}, 32'h0);
    check(fetch_addr === 32'h0, "R1 addr after reset", fetch_addr, 32'h0);
    @(posedge clk); #1;

    // ring 0x1000..0x10F0, frame start in the middle, idle reload
    cfg(2'd1, 32'h0000_1000);
    cfg(2'd2, 32'h0000_10F0);
    cfg(2'd0, 32'h0000_1080);
    pulse_vsync();
    push_ring(32'h0000_1080, 20, "R4 idle reload");
    bursts(20, 1'b0);

    // request now waiting; vsync plus unaligned frame start must not move it
    h = exp_next;
    cfg(2'd0, 32'h0000_10F7);
    pulse_vsync();
    @(negedge clk);
    check(fetch_req === 1'b1, "R6 req held across vsync", {31'b0, fetch_req}, 32'h1);
    check(fetch_addr === h, "R5 address not reloaded while waiting", fetch_addr, h);
    @(posedge clk); #1;
    q.push_back('{a: h, tag: exp_tag});
    push_ring(32'h0000_10F0, 6, "R5 deferred reload, R8 aligned");
    bursts(7, 1'b1);

    // code 3 write must not touch any register
    cfg(2'd3, 32'h0000_3000);
    pulse_vsync();
    q.push_back('{a: exp_next, tag: exp_tag});
    push_ring(32'h0000_10F0, 3, "R8 code 3 inert");
    bursts(4, 1'b0);

    // acknowledge with run low: request withdraws
    q.push_back('{a: exp_next, tag: "R7 last burst"});
    fetch_ack = 1'b1;
    @(posedge clk); #1;
    fetch_ack = 1'b0;
    @(negedge clk);
    check(fetch_req === 1'b0, "R7 req drops", {31'b0, fetch_req}, 32'h0);
    @(posedge clk); #1;

    // small four-burst ring
    cfg(2'd1, 32'h0000_2000);
    cfg(2'd2, 32'h0000_2030);
    cfg(2'd0, 32'h0000_2010);
    pulse_vsync();
    @(negedge clk);
    check(fetch_addr === 32'h0000_2010, "R4 idle reload next edge", fetch_addr, 32'h0000_2010);
    check(fetch_addr[3:0] === 4'h0, "R9 aligned", fetch_addr, fetch_addr & ~32'hF);
    @(posedge clk); #1;
    push_ring(32'h0000_2010, 10, "R4 reload small ring");
    bursts(10, 1'b1);

    // frame start beyond the last burst: equal-or-above wrap
    cfg(2'd0, 32'h0000_2040);
    pulse_vsync();
    q.push_back('{a: exp_next, tag: exp_tag});
    push_ring(32'h0000_2040, 5, "R5 reload beyond last");
    bursts(6, 1'b0);

    @(negedge clk);
    check(q.size() == 0, "R2 all expected bursts seen", q.size(), 32'h0);
    check(fetch_addr === exp_next, "R6 pending address", fetch_addr, exp_next);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule